// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the host-facing side of a serial port controller. An SPI master in mode 0 (clock idles low, data sampled on the rising edge) sends 16-bit frames. Each frame reads or writes one byte in a bank of 32 eight-bit registers. SCK, chip select and MOSI are oversampled in the system clock domain behind two-flop synchronizers, so the SPI clock must run well below the system clock.

A frame starts with a direction bit, then a 7-bit register address, then a data byte. On a read, the slave returns the addressed byte during the second half of the same frame. Address 0x00 holds no storage: it is the port into the UART FIFOs. A read from it pops the receive FIFO and a write to it pushes the transmit FIFO. The block drives one-cycle strobes for both and never pops an empty FIFO or pushes a full one. The two FIFO occupancies and a fixed revision code are visible as read-only registers.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is sent MSB first and is sampled on rising SCK while csn_i is low. Bit 15 is the direction (1 = write, 0 = read), bits 14:8 are the register address and bits 7:0 are the write data (zero on reads).
- R2: Addresses 0x01–0x1E, except 0x11 and 0x12, are storage. A write stores bits 7:0, and a later read returns that byte in the second returned byte, MSB first, changing on falling SCK. The first returned byte is 0x00.
- R3: Address 0x1F always reads 0xA1. Writes to it have no effect.
- R4: Address 0x11 reads tx_level_i and address 0x12 reads rx_level_i. Writes to either have no effect.
- R5: A read of address 0x00 while rx_level_i is nonzero raises rx_pop_o for exactly one clock cycle and returns rx_data_i as sampled in that cycle.
- R6: A read of address 0x00 while rx_level_i is 0 returns 0x00 and raises no rx_pop_o.
- R7: A write to address 0x00 raises tx_push_o for one clock cycle with tx_data_o equal to the data byte, but only when tx_level_i is below 128. At 128 the write is dropped.
- R8: If csn_i rises before the 16th SCK rising edge of a frame, the frame stores nothing and pushes nothing.
- R9: After reset all storage registers read 0x00, miso_o is low and neither strobe is active.
- R10: Addresses 0x20–0x7F read 0x00. Writes to them change no register.
- R11: SCK edges after the 16th in a frame, before csn_i rises, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock from master |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| rx_data_i | input | 8 | Head entry of the receive FIFO |
| rx_level_i | input | 8 | Receive FIFO occupancy, 0 to 128 |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_level_i | input | 8 | Transmit FIFO occupancy, 0 to 128 |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 8 | Byte to push into the transmit FIFO |

## Verification
A bit counter that slips by one shows up within the same frame. The returned byte comes back shifted by one position, and a write lands one address off, which the next read-back exposes. A read-data latch that is loaded too late leaves the first returned bit at zero. A strobe gate that tests the wrong level produces a pop or push count off by one at the empty or full boundary, and this is visible as soon as the frame ends. A frame that fails to clear on deselect carries stale bits into the next frame, so a completed write after an aborted one lands at the wrong address.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned ADDR_W     = DATA_W - 1;
  parameter int unsigned REG_N      = 32;
  parameter int unsigned FIFO_DEPTH = 128;

  parameter int unsigned FIFO_ADDR  = 'h00;
  parameter int unsigned TXLVL_ADDR = 'h11;
  parameter int unsigned RXLVL_ADDR = 'h12;
  parameter int unsigned REV_ADDR   = 'h1F;
  parameter logic [DATA_W-1:0] REV_ID = 8'hA1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = DW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          csn_s_i,
  input  logic          mosi_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic          wr_req_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          miso_o
);
  localparam int unsigned FRAME_W = 2 * DW;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);

  logic             sck_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-2:0]    in_sr_q;
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic [DW-1:0]    out_sr_q;
  logic             miso_q;

  logic          rise, fall, hdr_done, data_done;
  logic [DW-1:0] nxt_byte;

  assign rise      = sck_s_i & ~sck_q & ~csn_s_i;
  assign fall      = ~sck_s_i & sck_q & ~csn_s_i;
  assign nxt_byte  = {in_sr_q, mosi_s_i};
  assign hdr_done  = rise && (cnt_q == HDR_LAST);
  assign data_done = rise && (cnt_q == DATA_LAST);

  // header byte is consumed in the cycle it completes
  assign addr_o    = hdr_done ? nxt_byte[AW-1:0] : addr_q;
  assign rd_req_o  = hdr_done && !nxt_byte[DW-1];
  assign wr_req_o  = data_done && wr_q;
  assign wr_data_o = nxt_byte;
  assign miso_o    = miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cnt_q    <= '0;
      in_sr_q  <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      out_sr_q <= '0;
      miso_q   <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      if (csn_s_i) begin
        cnt_q    <= '0;
        out_sr_q <= '0;
        miso_q   <= 1'b0;
        wr_q     <= 1'b0;
      end else begin
        if (rise && cnt_q != CNT_FULL) begin
          in_sr_q <= nxt_byte[DW-2:0];
          cnt_q   <= cnt_q + 1'b1;
          if (hdr_done) begin
            wr_q   <= nxt_byte[DW-1];
            addr_q <= nxt_byte[AW-1:0];
            if (!nxt_byte[DW-1]) out_sr_q <= rd_data_i;
          end
        end
        if (fall) begin
          miso_q   <= out_sr_q[DW-1];
          out_sr_q <= {out_sr_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  a_r11_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  a_r8_write_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> (cnt_q == CNT_FULL || csn_s_i));
  a_r9_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> !miso_q);
  a_r1_single_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done |=> !hdr_done);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned AW         = DW - 1,
  parameter int unsigned NREG       = REG_N,
  parameter int unsigned DEPTH      = FIFO_DEPTH,
  parameter int unsigned LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [DW-1:0]    rx_data_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic             rx_pop_o,
  input  logic [LVL_W-1:0] tx_level_i,
  output logic             tx_push_o,
  output logic [DW-1:0]    tx_data_o
);
  localparam int unsigned RA_W = $clog2(NREG);

  logic [DW-1:0] regs_q [NREG];
  logic          in_range, is_fifo, rx_avail, tx_room;

  assign in_range = addr_i < AW'(NREG);
  assign is_fifo  = addr_i == AW'(FIFO_ADDR);
  assign rx_avail = rx_level_i != '0;
  assign tx_room  = tx_level_i < LVL_W'(DEPTH);

  assign rx_pop_o  = rd_req_i && is_fifo && rx_avail;
  assign tx_push_o = wr_req_i && is_fifo && tx_room;
  assign tx_data_o = wr_data_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == FIFO_ADDR || g == TXLVL_ADDR || g == RXLVL_ADDR || g == REV_ADDR) begin : g_none
      assign regs_q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_req_i && addr_i == AW'(g)) regs_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    if (!in_range)                     rd_data_o = '0;
    else if (is_fifo)                  rd_data_o = rx_avail ? rx_data_i : '0;
    else if (addr_i == AW'(TXLVL_ADDR)) rd_data_o = DW'(tx_level_i);
    else if (addr_i == AW'(RXLVL_ADDR)) rd_data_o = DW'(rx_level_i);
    else if (addr_i == AW'(REV_ADDR))   rd_data_o = REV_ID;
    else                               rd_data_o = regs_q[addr_i[RA_W-1:0]];
  end

  a_r5_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pop_o);
  a_r7_push_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |=> !tx_push_o);
  a_r7_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> tx_level_i < LVL_W'(DEPTH));
  a_r6_pop_push_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_pop_o && tx_push_o));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = DW - 1,
  parameter int unsigned NREG  = REG_N,
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic [DW-1:0]    rx_data_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic             rx_pop_o,
  input  logic [LVL_W-1:0] tx_level_i,
  output logic             tx_push_o,
  output logic [DW-1:0]    tx_data_o
);
  logic [2:0]    pins_s;
  logic          rd_req, wr_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;

  // order: {csn, sck, mosi}; chip select resets deasserted
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sck_i, mosi_i}),
    .q_o   (pins_s)
  );

  spi_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_s_i  (pins_s[1]),
    .csn_s_i  (pins_s[2]),
    .mosi_s_i (pins_s[0]),
    .rd_data_i(rd_data),
    .rd_req_o (rd_req),
    .wr_req_o (wr_req),
    .addr_o   (addr),
    .wr_data_o(wr_data),
    .miso_o   (miso_o)
  );

  spi_reg_bank #(.DW(DW), .AW(AW), .NREG(NREG), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_i  (rd_req),
    .wr_req_i  (wr_req),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .rx_data_i (rx_data_i),
    .rx_level_i(rx_level_i),
    .rx_pop_o  (rx_pop_o),
    .tx_level_i(tx_level_i),
    .tx_push_o (tx_push_o),
    .tx_data_o (tx_data_o)
  );

  a_r8_no_push_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s[2] |-> !tx_push_o);
endmodule

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
  localparam int HALF = 8;
  localparam int NV   = 16;
  // {check, req, frame, expected second byte}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd2,  16'h895A, 8'h00},  // R2 write 0x09
    {1'b1, 4'd2,  16'h0900, 8'h5A},  // R2
    {1'b0, 4'd2,  16'h9EC3, 8'h00},  // R2 top storage address
    {1'b1, 4'd2,  16'h1E00, 8'hC3},
    {1'b0, 4'd2,  16'h8101, 8'h00},  // R2 lowest storage address
    {1'b1, 4'd2,  16'h0100, 8'h01},
    {1'b1, 4'd2,  16'h0900, 8'h5A},
    {1'b0, 4'd3,  16'h9F00, 8'h00},  // R3 write ignored
    {1'b1, 4'd3,  16'h1F00, 8'hA1},
    {1'b0, 4'd4,  16'h91FF, 8'h00},  // R4
    {1'b1, 4'd4,  16'h1100, 8'h25},
    {1'b0, 4'd4,  16'h92FF, 8'h00},
    {1'b1, 4'd4,  16'h1200, 8'h00},
    {1'b0, 4'd10, 16'hA599, 8'h00},  // R10 no alias to 0x05
    {1'b1, 4'd10, 16'h2500, 8'h00},
    {1'b1, 4'd10, 16'h0500, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, rx_pop, tx_push;
  logic [7:0] rx_data = 8'h00, rx_level = 8'd0, tx_level = 8'd37, tx_data;
  int         n_chk = 0, n_fail = 0, pop_n = 0, push_n = 0;
  logic [7:0] last_tx = 8'h00;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .rx_data_i(rx_data), .rx_level_i(rx_level), .rx_pop_o(rx_pop),
    .tx_level_i(tx_level), .tx_push_o(tx_push), .tx_data_o(tx_data)
  );

  always @(negedge clk) begin
    if (rx_pop) pop_n++;
    if (tx_push) begin push_n++; last_tx = tx_data; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int nb, output logic [31:0] r);
    r = '0;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = w[31-i];
      repeat (HALF) @(negedge clk);
      r[31-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    logic [31:0] r;
    xfer({1'b0, a, 8'h00, 16'h0}, 16, r);
    v = r[23:16];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  v;
    int          p0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 miso idle", {31'b0, miso}, 32'h0);
    chk("R9 strobes idle", {30'b0, rx_pop, tx_push}, 32'h0);
    rd(7'h0A, v);
    chk("R9 storage reset", {24'b0, v}, 32'h0);

    // table walk (R1 framing used throughout)
    for (int k = 0; k < NV; k++) begin
      xfer({VEC[k][23:8], 16'h0}, 16, r);
      if (VEC[k][28]) begin
        chk($sformatf("R%0d vec %0d data", VEC[k][27:24], k), {24'b0, r[23:16]}, {24'b0, VEC[k][7:0]});
        chk($sformatf("R2 vec %0d first byte", k), {24'b0, r[31:24]}, 32'h0);
      end
    end

    tx_level = 8'h80;
    rd(7'h11, v);
    chk("R4 tx level", {24'b0, v}, 32'h80);

    // R5 pop from non-empty
    rx_level = 8'd3; rx_data = 8'h77; p0 = pop_n;
    rd(7'h00, v);
    chk("R5 pop data", {24'b0, v}, 32'h77);
    chk("R5 pop count", pop_n - p0, 1);

    // R6 empty
    rx_level = 8'd0; rx_data = 8'h55; p0 = pop_n;
    rd(7'h00, v);
    chk("R6 empty data", {24'b0, v}, 32'h0);
    chk("R6 no pop", pop_n - p0, 0);

    // R7 push boundaries
    tx_level = 8'd37; p0 = push_n;
    xfer(32'h803C_0000, 16, r);
    chk("R7 push count", push_n - p0, 1);
    chk("R7 push data", {24'b0, last_tx}, 32'h3C);
    tx_level = 8'd127; p0 = push_n;
    xfer(32'h8096_0000, 16, r);
    chk("R7 push at 127", push_n - p0, 1);
    chk("R7 push data 127", {24'b0, last_tx}, 32'h96);
    tx_level = 8'd128; p0 = push_n;
    xfer(32'h80AA_0000, 16, r);
    chk("R7 full drop", push_n - p0, 0);

    // R8 aborted frames
    xfer(32'h8AFF_0000, 12, r);
    rd(7'h0A, v);
    chk("R8 aborted write", {24'b0, v}, 32'h0);
    tx_level = 8'd0; p0 = push_n;
    xfer(32'h8011_0000, 15, r);
    chk("R8 aborted push", push_n - p0, 0);
    xfer(32'h8B42_0000, 16, r);
    rd(7'h0B, v);
    chk("R8 clean frame after abort", {24'b0, v}, 32'h42);

    // R11 excess clocks
    xfer(32'h8C11_FF00, 24, r);
    rd(7'h0C, v);
    chk("R11 excess bits", {24'b0, v}, 32'h11);
    rd(7'h0D, v);
    chk("R11 neighbour untouched", {24'b0, v}, 32'h0);

    finish_run();
  end
endmodule